// File: doc/BRIEF.md
# Banked Interrupt Source Controller

This block gathers up to 160 interrupt request lines into banks of 32 and drives one summary request per bank toward the processor. Each source is first passed through a two-flop synchroniser. A per-source trigger mode then turns it into a pending bit. The mode is chosen from two configuration bits, a polarity bit and an edge-select bit, and covers active-high level, active-low level, rising edge and falling edge. A bank's summary line is high whenever any pending source of that bank is also enabled.

Software reaches the block through a simple word register bus with address, write data, write strobe, read strobe and read data. Each bank has a window of six 32-bit words. Banks are spaced 24 bytes apart, so bank n begins at byte address 24*n. Pending bits can be forced high through a write-one-to-set word and dropped through a write-one-to-clear word. Picking the highest-priority source and cascading toward the processor are left to software.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, every enable word is 0 and every pending bit is 0. Every polarity word is 0xFFFFFFFF. The edge-select word is 0x0000E000 in bank 0 and 0 in the other banks. All summary lines are low.
- R2: Bank n occupies byte addresses 24*n to 24*n+23. The word at byte offset 0x0 is the pending status, 0x4 is enable, 0x8 is set, 0xC is clear, 0x10 is polarity and 0x14 is edge-select. Source s is held in bank s/32 at bit s%32 of src_in. Read data appears on bus_rdata on the clock edge that samples bus_re.
- R3: With edge-select 0, the pending bit follows the synchronised input live. It is active-high when polarity is 1 and active-low when polarity is 0. Writing 1 to its clear bit while the level is still active leaves it reading 1.
- R4: With edge-select 1, polarity 1 latches the pending bit on a rising input edge and polarity 0 latches it on a falling edge. The bit then stays 1 after the input returns, until it is cleared.
- R5: Writing 1 to a bit of the set word forces that pending bit to 1, and an edge-mode bit then holds it. Writing 0 bits to the set word changes nothing.
- R6: Writing 1 to a bit of the clear word drops that edge-mode pending bit to 0. Bits written 0 are unchanged.
- R7: The set and clear words read back as 0. Writes to the status word have no effect.
- R8: Summary line n equals the OR of (pending AND enable) of bank n. Clearing an enable bit masks that source but leaves its pending bit unchanged.
- R9: The enable, polarity and edge-select words read back the last value written to them.
- R10: Addresses at or above 24*NUM_BANKS read as 0, and writes to them change no register.
- R11: A level change on an enabled level-mode input reaches the summary line on the third rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_BANKS*32 | Asynchronous interrupt source lines |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| bank_irq | output | NUM_BANKS | Per-bank summary request |

## Verification
The hardest situations to reach are the changes of trigger mode while a source is already pending. One case is an edge-mode bit that keeps a latched 1 after its input has gone inactive and is then switched to level mode, where it must fall back to the live level. The other is a level bit switched to edge mode, where it must keep whatever it last showed. The random phase mixes polarity, edge-select, set and clear writes with input changes on the same bank. A bench model tracks settled inputs and reached modes, and it reads status after every step. Directed cases pin the three-edge synchroniser latency and the clear-while-level-active corner.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BANK_STRIDE = 24;

  typedef enum logic [2:0] {
    RG_STATUS = 3'd0,
    RG_ENABLE = 3'd1,
    RG_SET    = 3'd2,
    RG_CLEAR  = 3'd3,
    RG_POL    = 3'd4,
    RG_EDGE   = 3'd5
  } reg_sel_e;

  // Qualified level: a bit is active when input equals its polarity bit.
  function automatic logic [31:0] active_of(input logic [31:0] lvl, input logic [31:0] pol);
    return ~(lvl ^ pol);
  endfunction

  // Transition into the active state between two synchronised samples.
  function automatic logic [31:0] edge_hit(input logic [31:0] cur, input logic [31:0] prev,
                                           input logic [31:0] pol);
    return active_of(cur, pol) & ~active_of(prev, pol);
  endfunction

  function automatic logic [31:0] bank_of(input logic [31:0] addr);
    return addr / BANK_STRIDE;
  endfunction

  function automatic logic [2:0] word_of(input logic [31:0] addr);
    logic [31:0] r;
    r = (addr % BANK_STRIDE) >> 2;
    return r[2:0];
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta   <= '0;
      q      <= '0;
      q_prev <= '0;
    end else begin
      meta   <= d;
      q      <= meta;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter logic [31:0] EDGE_RST = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] lvl,
  input  logic [31:0] lvl_prev,
  input  logic        wr_en,
  input  logic        wr_set,
  input  logic        wr_clr,
  input  logic        wr_pol,
  input  logic        wr_edge,
  input  logic [31:0] wdata,
  output logic [31:0] pend,
  output logic [31:0] en,
  output logic [31:0] pol,
  output logic [31:0] edge_sel,
  output logic        irq
);
  logic [31:0] act, hit, set_m, clr_m, pend_nx;

  assign act   = active_of(lvl, pol);
  assign hit   = edge_hit(lvl, lvl_prev, pol);
  assign set_m = wr_set ? wdata : '0;
  assign clr_m = wr_clr ? wdata : '0;

  always_comb begin
    pend_nx = (edge_sel & ((pend & ~clr_m) | hit)) | (~edge_sel & act) | set_m;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      en       <= '0;
      pol      <= '1;
      edge_sel <= EDGE_RST;
    end else begin
      pend <= pend_nx;
      if (wr_en)   en       <= wdata;
      if (wr_pol)  pol      <= wdata;
      if (wr_edge) edge_sel <= wdata;
    end
  end

  assign irq = |(pend & en);

  // R6
  edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pend & $past(wdata & edge_sel & ~hit)) == '0));
  // R5
  set_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((pend & $past(wdata)) == $past(wdata)));
  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & edge_sel & ~clr_m)) |=>
      ((pend & $past(pend & edge_sel & ~clr_m)) == $past(pend & edge_sel & ~clr_m)));
  // R3
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~edge_sel & ~set_m)) |=>
      ((pend & $past(~edge_sel & ~set_m)) == $past(act & ~edge_sel & ~set_m)));
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int          NUM_BANKS      = 4,
  parameter int          ADDR_W         = 8,
  parameter logic [31:0] BANK0_EDGE_RST = 32'h0000_E000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_BANKS*32-1:0]   src_in,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  input  logic                      bus_we,
  input  logic                      bus_re,
  output logic [31:0]               bus_rdata,
  output logic [NUM_BANKS-1:0]      bank_irq
);
  localparam int SRC_W = NUM_BANKS * 32;

  logic [SRC_W-1:0] lvl_s, lvl_p;
  logic [31:0]      addr32, acc_bank;
  logic [2:0]       acc_word;
  logic             in_range, rd_wo_hit, rd_miss;
  logic [31:0]      pend_a [NUM_BANKS];
  logic [31:0]      en_a   [NUM_BANKS];
  logic [31:0]      pol_a  [NUM_BANKS];
  logic [31:0]      edge_a [NUM_BANKS];
  logic [31:0]      rd_val;

  assign addr32    = 32'(bus_addr);
  assign acc_bank  = bank_of(addr32);
  assign acc_word  = word_of(addr32);
  assign in_range  = acc_bank < 32'(NUM_BANKS);
  assign rd_wo_hit = bus_re && in_range &&
                     (acc_word == RG_SET || acc_word == RG_CLEAR);
  assign rd_miss   = bus_re && !in_range;

  irqc_sync #(.W(SRC_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_in), .q(lvl_s), .q_prev(lvl_p)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = bus_we && in_range && (acc_bank == 32'(b));
    irqc_bank #(.EDGE_RST(b == 0 ? BANK0_EDGE_RST : 32'h0)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .lvl(lvl_s[b*32 +: 32]), .lvl_prev(lvl_p[b*32 +: 32]),
      .wr_en(sel && acc_word == RG_ENABLE),
      .wr_set(sel && acc_word == RG_SET),
      .wr_clr(sel && acc_word == RG_CLEAR),
      .wr_pol(sel && acc_word == RG_POL),
      .wr_edge(sel && acc_word == RG_EDGE),
      .wdata(bus_wdata),
      .pend(pend_a[b]), .en(en_a[b]), .pol(pol_a[b]), .edge_sel(edge_a[b]),
      .irq(bank_irq[b])
    );
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (in_range && acc_bank == 32'(i)) begin
        case (acc_word)
          RG_STATUS: rd_val = pend_a[i];
          RG_ENABLE: rd_val = en_a[i];
          RG_POL:    rd_val = pol_a[i];
          RG_EDGE:   rd_val = edge_a[i];
          default:   rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_val;
  end

  // R7
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wo_hit |=> (bus_rdata == '0));
  // R10
  miss_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_miss |=> (bus_rdata == '0));
endmodule

// File: tb/sim_banked_irq_ctrl.sv
module sim_banked_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int STRIDE = 24;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [NB*32-1:0]  src_in = '0;
  logic [7:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_we = 0, bus_re = 0;
  logic [31:0]       bus_rdata;
  logic [NB-1:0]     bank_irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_en [NB], m_pol [NB], m_edge [NB], m_pend [NB], m_in [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .bank_irq(bank_irq)
  );

  function automatic logic [31:0] qual(input logic [31:0] v, input logic [31:0] p);
    return (p & v) | (~p & ~v);
  endfunction

  function automatic logic [7:0] reg_addr(input int b, input int idx);
    return 8'(b * STRIDE + idx * 4);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_raw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd_raw(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1;
    @(negedge clk);
    bus_re = 0; d = bus_rdata;
  endtask

  task automatic relevel(input int b);
    m_pend[b] = (m_pend[b] & m_edge[b]) | (~m_edge[b] & qual(m_in[b], m_pol[b]));
  endtask

  // idx: 1 enable, 2 set, 3 clear, 4 polarity, 5 edge
  task automatic wr_model(input int b, input int idx, input logic [31:0] d);
    wr_raw(reg_addr(b, idx), d);
    case (idx)
      1: m_en[b] = d;
      2: m_pend[b] = m_pend[b] | (d & m_edge[b]);
      3: m_pend[b] = m_pend[b] & ~(d & m_edge[b]);
      4: m_pol[b] = d;
      5: m_edge[b] = d;
      default: ;
    endcase
    relevel(b);
  endtask

  task automatic drive_in(input int b, input logic [31:0] v);
    logic [31:0] hit;
    @(negedge clk);
    src_in[b*32 +: 32] = v;
    ticks(4);
    hit = m_edge[b] & ((m_pol[b] & ~m_in[b] & v) | (~m_pol[b] & m_in[b] & ~v));
    m_in[b] = v;
    m_pend[b] = m_pend[b] | hit;
    relevel(b);
  endtask

  task automatic check_bank(input int b, input string req);
    logic [31:0] d;
    rd_raw(reg_addr(b, 0), d); check({req, " status"}, d, m_pend[b]);
    rd_raw(reg_addr(b, 1), d); check({req, " enable"}, d, m_en[b]);
    check({req, " R8 irq"}, 32'(bank_irq[b]), 32'(|(m_pend[b] & m_en[b])));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    for (int b = 0; b < NB; b++) begin
      m_en[b] = '0; m_pol[b] = '1; m_pend[b] = '0; m_in[b] = '0;
      m_edge[b] = (b == 0) ? 32'h0000_E000 : 32'h0;
    end
    ticks(3);
    rst_n = 1;
    ticks(1);

    // R1 reset values
    check("R1 irq", 32'(bank_irq), 32'h0);
    for (int b = 0; b < NB; b++) begin
      rd_raw(reg_addr(b, 0), d); check("R1 status", d, 32'h0);
      rd_raw(reg_addr(b, 1), d); check("R1 enable", d, 32'h0);
      rd_raw(reg_addr(b, 4), d); check("R1 polarity", d, 32'hFFFF_FFFF);
      rd_raw(reg_addr(b, 5), d); check("R1 edge", d, b == 0 ? 32'h0000_E000 : 32'h0);
    end

    // R11 latency through synchroniser, bank 1 bit 3 active-high level
    wr_model(1, 1, 32'h8);
    @(negedge clk); src_in[32 + 3] = 1'b1;
    @(negedge clk); check("R11 before edge2", 32'(bank_irq[1]), 32'h0);
    @(negedge clk); check("R11 before edge3", 32'(bank_irq[1]), 32'h0);
    @(negedge clk); check("R11 at edge3", 32'(bank_irq[1]), 32'h1);
    ticks(2);
    m_in[1] = 32'h8; relevel(1);
    check_bank(1, "R11");

    // R2 source 70 maps to bank 2 bit 6
    drive_in(2, 32'h40);
    check_bank(2, "R2 map");

    // R3 active-low level, clear while still active
    wr_model(3, 4, 32'hFFFF_FFFE);
    check_bank(3, "R3 low level");
    wr_model(3, 3, 32'h1);
    rd_raw(reg_addr(3, 0), d); check("R3 clear on active level", d[0] ? 32'h1 : 32'h0, 32'h1);
    drive_in(3, 32'h1);
    rd_raw(reg_addr(3, 0), d); check("R3 inactive low level", 32'(d[0]), 32'h0);

    // R4 rising edge on bank 0 bit 13 (edge mode after reset)
    wr_model(0, 1, 32'h2000);
    drive_in(0, 32'h2000);
    drive_in(0, 32'h0);
    rd_raw(reg_addr(0, 0), d); check("R4 rising held", d, 32'h2000);
    check("R4 irq", 32'(bank_irq[0]), 32'h1);
    wr_model(0, 3, 32'h2000);
    rd_raw(reg_addr(0, 0), d); check("R6 clear edge", d, 32'h0);
    // R4 falling edge on bit 14
    wr_model(0, 4, 32'hFFFF_BFFF);
    drive_in(0, 32'h4000);
    rd_raw(reg_addr(0, 0), d); check("R4 no latch on rise in falling mode", d, 32'h0);
    drive_in(0, 32'h0);
    rd_raw(reg_addr(0, 0), d); check("R4 falling latched", d, 32'h4000);

    // R8 mask keeps status
    wr_model(0, 1, 32'h0);
    check("R8 masked irq", 32'(bank_irq[0]), 32'h0);
    rd_raw(reg_addr(0, 0), d); check("R8 status kept", d, 32'h4000);

    // R5 set on edge bit, zeros no effect; R7 readback zero and status write ignored
    wr_model(0, 2, 32'h0000_8000);
    rd_raw(reg_addr(0, 0), d); check("R5 set forced", d, 32'h0000_C000);
    wr_model(0, 2, 32'h0);
    rd_raw(reg_addr(0, 0), d); check("R5 zero set", d, 32'h0000_C000);
    rd_raw(reg_addr(0, 2), d); check("R7 set reads 0", d, 32'h0);
    rd_raw(reg_addr(0, 3), d); check("R7 clear reads 0", d, 32'h0);
    wr_raw(reg_addr(0, 0), 32'h0);
    rd_raw(reg_addr(0, 0), d); check("R7 status write ignored", d, 32'h0000_C000);

    // R9 readback
    wr_model(2, 5, 32'hA5A5_0000);
    rd_raw(reg_addr(2, 5), d); check("R9 edge readback", d, 32'hA5A5_0000);
    rd_raw(reg_addr(0, 4), d); check("R9 pol readback", d, m_pol[0]);

    // R10 out-of-range
    wr_raw(8'(NB * STRIDE + 4), 32'hFFFF_FFFF);
    rd_raw(8'(NB * STRIDE + 4), d); check("R10 miss read", d, 32'h0);
    for (int b = 0; b < NB; b++) check_bank(b, "R10 no write");

    // Random phase: mode changes mixed with inputs, set and clear
    for (int it = 0; it < 400; it++) begin
      int b, op;
      logic [31:0] r;
      b = int'($urandom_range(NB - 1, 0));
      op = int'($urandom_range(5, 0));
      r = $urandom();
      case (op)
        0: drive_in(b, m_in[b] ^ (r & $urandom()));
        1: wr_model(b, 1, r);
        2: wr_model(b, 2, r & $urandom());
        3: wr_model(b, 3, r);
        4: wr_model(b, 4, r);
        default: wr_model(b, 5, r);
      endcase
      check_bank(b, "R3 R4 R5 R6 R8 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule